// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a bitstream into a target FPGA through its slave-serial configuration pins. It owns three outputs toward the target: an active-low program strobe, a configuration clock and a serial data line. It watches two status lines coming back: init and done. A start request begins a three-phase handshake. First the program strobe goes low until the target pulls init low. Then the strobe is released and the block waits for init to return high. Only then does it accept configuration bits.

Bits arrive one at a time from an upstream source over a valid/ready handshake, with a last-bit flag that marks the end of the stream. Each bit is sent to the target as four equal-length steps of clock and data. After the last bit the block waits for done. Every wait phase has its own timeout, measured in ticks of a prescaled millisecond timebase, and its own error code. A one-cycle finished pulse reports the outcome, and a two-bit result output holds that outcome until the next start.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset, prog_n, cfg_clk and cfg_dat are 1, bit_ready and finished are 0, and result is 0.
- R2: A start in idle drives prog_n to 0 while cfg_clk and cfg_dat stay 1. prog_n returns to 1 once the synchronised init line is seen low.
- R3: bit_ready stays 0 until init has been seen high again after program was released, and also in every other phase except bit transfer.
- R4: Each bit uses four steps of STEP_CLKS system clocks each, in this order: (clock 0, data 1), (clock 0, data = bit), (clock 1, data = bit), (clock 1, data 1). cfg_clk therefore stays low for exactly 2*STEP_CLKS cycles per bit, cfg_dat is 1 when cfg_clk falls, and the bit value is present when cfg_clk rises.
- R5: A bit is taken only on a cycle where both bit_valid and bit_ready are 1. Bits go out in the order they are taken. A bit_valid outside the transfer phase produces no cfg_clk edge.
- R6: The timebase ticks every TICK_DIV cycles, counted from the first cycle of each wait phase. A phase that is still waiting on tick number TMO_LIM+2 fails. With the default limit of 3, prog_n is low for exactly 5*TICK_DIV cycles when init never falls.
- R7: The error codes are: result 1 when init did not fall, result 2 when init did not rise, and result 3 when done did not rise after the last bit.
- R8: If done goes high while the block waits after the last bit, the block reports result 0.
- R9: finished is high for exactly one cycle per run. result holds its value until the next start, and all three target outputs are 1 after the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (taken in idle) |
| bit_valid | input | 1 | Upstream offers a bit |
| bit_data | input | 1 | Bit value |
| bit_last | input | 1 | Offered bit is the final one |
| bit_ready | output | 1 | Block can take a bit this cycle |
| tgt_init | input | 1 | Target init status line (asynchronous) |
| tgt_done | input | 1 | Target done status line (asynchronous) |
| prog_n | output | 1 | Active-low program strobe to target |
| cfg_clk | output | 1 | Configuration clock to target |
| cfg_dat | output | 1 | Serial configuration data to target |
| finished | output | 1 | One-cycle pulse when a run ends |
| result | output | 2 | Outcome code: 0 ok, 1/2/3 per R7 |

## Verification
If the phase register is wrong, it shows at prog_n or bit_ready within one cycle. It also shows as a timeout code reached after the wrong number of cycles, since the bench measures each timeout against 5*TICK_DIV. A wrong step counter in the bit engine changes the low width of cfg_clk on the very next bit. It can also let a data change land on a rising clock edge, and then the target model captures a different byte. Every 8-bit pattern is sent and read back, so a fault in the order of bits or in their values appears at the end of the affected run.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_PROG      = 3'd1,
        PH_INIT_WAIT = 3'd2,
        PH_SHIFT     = 3'd3,
        PH_DONE_WAIT = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        RES_OK           = 2'd0,
        RES_NO_INIT_LOW  = 2'd1,
        RES_NO_INIT_HIGH = 2'd2,
        RES_NO_DONE      = 2'd3
    } result_t;

    typedef enum logic [1:0] {
        ST_CLK_LO  = 2'd0,
        ST_DAT_SET = 2'd1,
        ST_CLK_HI  = 2'd2,
        ST_DAT_REL = 2'd3
    } bstep_t;

    typedef struct packed {
        logic clk;
        logic dat;
    } wire_pair_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic wire_pair_t step_drive(input bstep_t st, input logic b);
        wire_pair_t w;
        unique case (st)
            ST_CLK_LO:  w = '{clk: 1'b0, dat: 1'b1};
            ST_DAT_SET: w = '{clk: 1'b0, dat: b};
            ST_CLK_HI:  w = '{clk: 1'b1, dat: b};
            default:    w = '{clk: 1'b1, dat: 1'b1};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= RST_VAL;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgseq_tick.sv
module cfgseq_tick
    import cfgseq_pkg::*;
#(
    parameter int unsigned DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned W = cnt_width(DIV);
    localparam logic [W-1:0] TOP = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    a_r6_tick_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);
endmodule

// File: rtl/cfgseq_watch.sv
module cfgseq_watch #(
    parameter int unsigned LIM = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIM + 2) + 1;
    localparam logic [CW-1:0] LIM_V = CW'(LIM);

    logic [CW-1:0] ticks;

    assign expired = tick && (ticks > LIM_V);

    always_ff @(posedge clk) begin
        if (rst || clr)
            ticks <= '0;
        else if (tick && ticks <= LIM_V)
            ticks <= ticks + 1'b1;
    end

    a_r6_tick_count_bounded: assert property (@(posedge clk) disable iff (rst)
        ticks <= LIM_V + 1'b1);
endmodule

// File: rtl/cfgseq_bitgen.sv
module cfgseq_bitgen
    import cfgseq_pkg::*;
#(
    parameter int unsigned STEP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic bit_last,
    output logic bit_ready,
    output logic cfg_clk,
    output logic cfg_dat,
    output logic stream_end
);
    localparam int unsigned SW = cnt_width(STEP);
    localparam logic [SW-1:0] STEP_TOP = SW'(STEP - 1);

    logic          busy;
    bstep_t        step;
    logic [SW-1:0] scnt;
    logic          cur_bit;
    logic          cur_last;
    wire_pair_t    drv;

    assign bit_ready = en && !busy;

    always_comb begin
        if (busy)
            drv = step_drive(step, cur_bit);
        else
            drv = '{clk: 1'b1, dat: 1'b1};
    end

    assign cfg_clk = drv.clk;
    assign cfg_dat = drv.dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            step       <= ST_CLK_LO;
            scnt       <= '0;
            cur_bit    <= 1'b1;
            cur_last   <= 1'b0;
            stream_end <= 1'b0;
        end else begin
            stream_end <= 1'b0;
            if (!busy) begin
                if (bit_valid && bit_ready) begin
                    busy     <= 1'b1;
                    step     <= ST_CLK_LO;
                    scnt     <= '0;
                    cur_bit  <= bit_data;
                    cur_last <= bit_last;
                end
            end else if (scnt == STEP_TOP) begin
                scnt <= '0;
                if (step == ST_DAT_REL) begin
                    busy       <= 1'b0;
                    stream_end <= cur_last;
                end else begin
                    step <= bstep_t'(step + 2'd1);
                end
            end else begin
                scnt <= scnt + 1'b1;
            end
        end
    end

    a_r4_data_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_clk) |-> $stable(cfg_dat));
    a_r4_high_at_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_clk) |-> cfg_dat);
    a_r5_no_take_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !bit_ready);
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
    import cfgseq_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 100000,
    parameter int unsigned STEP_CLKS   = 4,
    parameter int unsigned TMO_LIM     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bit_valid,
    input  logic       bit_data,
    input  logic       bit_last,
    output logic       bit_ready,
    input  logic       tgt_init,
    input  logic       tgt_done,
    output logic       prog_n,
    output logic       cfg_clk,
    output logic       cfg_dat,
    output logic       finished,
    output logic [1:0] result
);
    phase_t  state_q, state_d;
    result_t res_q, res_d;
    logic    fin_d, fin_q;
    logic    init_s, done_s;
    logic    phase_clr, tick, expired, stream_end;

    cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
        .clk(clk), .rst(rst), .d(tgt_init), .q(init_s));

    cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst(rst), .d(tgt_done), .q(done_s));

    cfgseq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .clr(phase_clr), .tick(tick));

    cfgseq_watch #(.LIM(TMO_LIM)) u_watch (
        .clk(clk), .rst(rst), .clr(phase_clr), .tick(tick), .expired(expired));

    cfgseq_bitgen #(.STEP(STEP_CLKS)) u_bits (
        .clk(clk), .rst(rst), .en(state_q == PH_SHIFT),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_last(bit_last),
        .bit_ready(bit_ready), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
        .stream_end(stream_end));

    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        fin_d   = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    state_d = PH_PROG;
                    res_d   = RES_OK;
                end
            end
            PH_PROG: begin
                if (!init_s) begin
                    state_d = PH_INIT_WAIT;
                end else if (expired) begin
                    state_d = PH_IDLE;
                    res_d   = RES_NO_INIT_LOW;
                    fin_d   = 1'b1;
                end
            end
            PH_INIT_WAIT: begin
                if (init_s) begin
                    state_d = PH_SHIFT;
                end else if (expired) begin
                    state_d = PH_IDLE;
                    res_d   = RES_NO_INIT_HIGH;
                    fin_d   = 1'b1;
                end
            end
            PH_SHIFT: begin
                if (stream_end)
                    state_d = PH_DONE_WAIT;
            end
            PH_DONE_WAIT: begin
                if (done_s) begin
                    state_d = PH_IDLE;
                    res_d   = RES_OK;
                    fin_d   = 1'b1;
                end else if (expired) begin
                    state_d = PH_IDLE;
                    res_d   = RES_NO_DONE;
                    fin_d   = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    assign phase_clr = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            res_q   <= RES_OK;
            fin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            fin_q   <= fin_d;
        end
    end

    assign prog_n   = (state_q != PH_PROG);
    assign finished = fin_q;
    assign result   = res_q;

    a_r2_strobe_with_lines_high: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> (cfg_clk && cfg_dat));
    a_r3_ready_only_in_transfer: assert property (@(posedge clk) disable iff (rst)
        bit_ready |-> (state_q == PH_SHIFT));
    a_r9_finish_single_cycle: assert property (@(posedge clk) disable iff (rst)
        finished |=> !finished);
    a_r9_result_held_in_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_IDLE && !start) |=> $stable(result));
    a_r9_idle_after_finish: assert property (@(posedge clk) disable iff (rst)
        finished |-> (prog_n && cfg_clk && cfg_dat));
endmodule

// File: tb/sim_fpga_serial_loader.sv
module sim_fpga_serial_loader;
    localparam int DIV  = 8;
    localparam int STEP = 2;
    localparam int LIM  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0, bit_last = 1'b0;
    logic tgt_init = 1'b1, tgt_done = 1'b0;
    logic bit_ready, prog_n, cfg_clk, cfg_dat, finished;
    logic [1:0] result;

    int n_chk = 0, n_bad = 0;
    int rx_total = 0;
    logic [7:0] rx_shift = 8'h00;
    int exp_total = 0;
    bit m_fall = 1, m_rise = 1, m_done = 1;
    int dly = 0;
    int width_err = 0, fall_err = 0, r2_err = 0, r3_err = 0, low_cnt = 0;
    logic prev_clk = 1'b1;

    always #5 clk = ~clk;

    fpga_serial_loader #(.TICK_DIV(DIV), .STEP_CLKS(STEP), .TMO_LIM(LIM), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid), .bit_data(bit_data),
        .bit_last(bit_last), .bit_ready(bit_ready), .tgt_init(tgt_init), .tgt_done(tgt_done),
        .prog_n(prog_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat), .finished(finished),
        .result(result));

    // target model: captures on rising cfg_clk
    always @(posedge cfg_clk) begin
        if (!rst) begin
            rx_shift <= {rx_shift[6:0], cfg_dat};
            rx_total <= rx_total + 1;
        end
    end

    // target model: init/done behaviour
    always @(negedge clk) begin
        if (!prog_n) begin
            tgt_done <= 1'b0;
            if (m_fall && tgt_init) begin
                if (dly == 3) begin tgt_init <= 1'b0; dly <= 0; end
                else dly <= dly + 1;
            end
        end else if (!tgt_init) begin
            if (m_rise) begin
                if (dly == 4) begin tgt_init <= 1'b1; dly <= 0; end
                else dly <= dly + 1;
            end
        end else if (m_done && !tgt_done && rx_total == exp_total && exp_total != 0) begin
            if (dly == 2) begin tgt_done <= 1'b1; dly <= 0; end
            else dly <= dly + 1;
        end
    end

    // port monitors for R2, R3, R4
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_clk && !cfg_clk) begin
                if (!cfg_dat) fall_err++;
                low_cnt = 1;
            end else if (!cfg_clk) begin
                low_cnt++;
            end else if (!prev_clk && cfg_clk) begin
                if (low_cnt != 2*STEP) width_err++;
            end
            if (!prog_n && !(cfg_clk && cfg_dat)) r2_err++;
            if (bit_ready && !tgt_init) r3_err++;
            prev_clk = cfg_clk;
        end
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_fin(output int cyc);
        cyc = 0;
        while (!finished && cyc < 5000) begin @(negedge clk); cyc++; end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            bit_valid = 1'b1; bit_data = b[i]; bit_last = (i == 0);
            while (!bit_ready) @(negedge clk);
        end
        @(negedge clk);
        bit_valid = 1'b0; bit_last = 1'b0;
    endtask

    task automatic run_byte(input logic [7:0] b, input logic [1:0] exp_res);
        int cyc;
        exp_total = rx_total + 8;
        pulse_start();
        send_byte(b);
        wait_fin(cyc);
        chk("R5 byte capture", rx_shift == b, rx_shift, b);
        chk(exp_res == 0 ? "R8 success code" : "R7 done timeout code",
            result == exp_res, result, exp_res);
    endtask

    initial begin
        int k, base, c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 prog_n", prog_n == 1'b1, prog_n, 1);
        chk("R1 cfg_clk", cfg_clk == 1'b1, cfg_clk, 1);
        chk("R1 cfg_dat", cfg_dat == 1'b1, cfg_dat, 1);
        chk("R1 ready", bit_ready == 1'b0, bit_ready, 0);
        chk("R1 finished", finished == 1'b0, finished, 0);
        chk("R1 result", result == 2'd0, result, 0);

        // R5: valid in idle has no effect
        base = rx_total;
        @(negedge clk); bit_valid = 1'b1; bit_data = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (!cfg_clk || bit_ready) base = -1;
        end
        bit_valid = 1'b0;
        chk("R5 idle valid ignored", base == rx_total, base, rx_total);

        // R2/R6/R7: init never falls
        m_fall = 0;
        pulse_start();
        while (prog_n) @(negedge clk);
        k = 0;
        while (!finished && k < 1000) begin @(negedge clk); k++; end
        chk("R6 init-low timeout length", k == (LIM+2)*DIV, k, (LIM+2)*DIV);
        chk("R7 code init-low", result == 2'd1, result, 1);
        chk("R9 idle lines after fail", prog_n && cfg_clk && cfg_dat, {prog_n, cfg_clk, cfg_dat}, 7);
        @(negedge clk);
        chk("R9 finished one cycle", finished == 1'b0, finished, 0);
        repeat (5) @(negedge clk);
        chk("R9 result held", result == 2'd1, result, 1);
        m_fall = 1;

        // R3/R7: init falls but never rises
        m_rise = 0;
        base = rx_total;
        pulse_start();
        @(negedge clk); bit_valid = 1'b1; bit_data = 1'b1;
        while (!(prog_n && !tgt_init)) @(negedge clk);
        while (prog_n == 1'b1 && u0.prog_n == 1'b1 && tgt_init == 1'b0 && !prog_n) @(negedge clk);
        // measure from program release
        k = 0;
        while (!finished && k < 1000) begin @(negedge clk); k++; end
        bit_valid = 1'b0;
        chk("R7 code init-high", result == 2'd2, result, 2);
        chk("R3 no bits before init high", rx_total == base, rx_total, base);
        chk("R6 init-high timeout bounded", k <= (LIM+2)*DIV && k > (LIM+1)*DIV - 8, k, (LIM+2)*DIV);
        m_rise = 1;
        repeat (12) @(negedge clk);

        // R7: done never rises
        m_done = 0;
        run_byte(8'hA5, 2'd3);
        m_done = 1;

        // R8/R5/R4: every byte pattern
        c0 = n_bad;
        for (int v = 0; v < 256; v++) run_byte(v[7:0], 2'd0);
        chk("R5 sweep all patterns", n_bad == c0, n_bad - c0, 0);
        chk("R4 clock low width", width_err == 0, width_err, 0);
        chk("R4 data high at clock fall", fall_err == 0, fall_err, 0);
        chk("R2 lines high during program", r2_err == 0, r2_err, 0);
        chk("R3 ready while init low", r3_err == 0, r3_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule